// File: doc/BRIEF.md
# MDIO PHY Link Monitor

This block runs the management data line to the Ethernet PHYs by itself, so the host never has to start MDIO transactions. When reset is released it issues a clause-22 read of the status register at each of the 32 PHY addresses, lowest address first. It records in a bitmap which addresses answered. Once the scan is over, the host names one address and sets the monitor enable. From then on the block polls that PHY's status register continuously and keeps a copy of its link bit.

Each transition of the cached link state sets a sticky event flag: one flag for link coming up and one for link going down. Writing a 1 to a flag clears it. An interrupt output is raised while any flag is set whose enable bit is also set. The host reads the link state, the bitmap and the flags from four registers. A read is combinational and never starts a bus cycle.

The management clock is the system clock divided by twice a programmable half-period. The block drives data after the falling edge of MDC and samples the line at the rising edge. The line passes through a parameterised synchroniser before it is sampled.

Top module: `mdio_link_monitor`

## Requirements
- R1: After reset, mdc and mdio_oe are low, irq is low, the control register (address 0) reads DEF_HALF<<8, and the bitmap (address 1), status (address 2) and event (address 3) registers read 0.
- R2: MDC stays at each level for H system clocks, where H is control bits [15:8], and an H of 0 is treated as 1. The full period is therefore 2*H clocks.
- R3: Every frame drives 32 ones, then 0,1, then 1,0, then the 5-bit PHY address MSB first, then register address 00001, and then releases the line for 18 bit times. mdio_o and mdio_oe change only in the cycle in which MDC falls.
- R4: After reset exactly 32 scan frames are issued, addressed 0, 1, … 31 in that order.
- R5: Bit n of the bitmap (address 1) is 1 exactly when PHY n pulled the line low in the second turnaround bit of its scan frame.
- R6: Status bit 1 is set after the 32nd scan frame. No further frame starts while the monitor enable (control bit 5) is 0.
- R7: While monitoring, each frame addresses the PHY given by control bits [4:0]. A new selection applies from the next frame.
- R8: Status bit 0 takes data bit 2 of each monitored read. A 0→1 change sets event bit 0 and a 1→0 change sets event bit 1. A read that leaves the value unchanged sets no event.
- R9: Writing the event register clears each event bit written as 1 and leaves bits written as 0 unchanged.
- R10: irq is high exactly when (event bits AND control bits [7:6]) is nonzero.
- R11: Writes to the bitmap register have no effect.
- R12: A monitored PHY that does not answer in the turnaround counts as link down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select: 0 control, 1 bitmap, 2 status, 3 events |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | DIV_W+8 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data drive enable |
| mdio_i | input | 1 | Management data line as seen at the pin |
| irq | output | 1 | Interrupt request |

## Verification
The PHY model answers at only some addresses, including the first and the last. A design that mis-sampled the turnaround bit, or skipped either end of the address range, would show a wrong bitmap or a wrong frame order. The link sequence covers an unchanged read, both directions of change, and clear-one-bit writes. A design that raised events on every poll, or cleared the whole register on any write, would fail there. Moving the selection to an absent address must give a down event, and a write to the bitmap must leave it as it was. The divider is measured at a half-period of zero to catch a stalled or runaway MDC.

// File: rtl/mlm_pkg.sv
package mlm_pkg;
   localparam int PHY_AW     = 5;
   localparam int NUM_PHY    = 1 << PHY_AW;
   localparam int PRE_BITS   = 32;
   localparam int HDR_END    = PRE_BITS + 14;
   localparam int TA_LOW_BIT = HDR_END + 1;
   localparam int LAST_BIT   = 63;
   localparam int LINK_POS   = 2;
   localparam logic [4:0] STATUS_REG = 5'd1;

   localparam logic [1:0] RA_CTRL  = 2'd0;
   localparam logic [1:0] RA_ALIVE = 2'd1;
   localparam logic [1:0] RA_STAT  = 2'd2;
   localparam logic [1:0] RA_EVT   = 2'd3;

   typedef enum logic [1:0] {FE_IDLE, FE_ARM, FE_RUN} fe_st_t;
   typedef enum logic [1:0] {SQ_SCAN_GO, SQ_SCAN_WAIT, SQ_MON_GO, SQ_MON_WAIT} seq_st_t;
endpackage

// File: rtl/mlm_mdc_gen.sv
module mlm_mdc_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim;
   logic             tick;

   always_comb begin
      lim  = (half == '0) ? DIV_W'(1) : half;
      tick = (cnt_q >= lim - DIV_W'(1));
      rise = tick & ~mdc;
      fall = tick & mdc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (tick) begin
         cnt_q <= '0;
         mdc   <= ~mdc;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/mlm_frame_engine.sv
module mlm_frame_engine
   import mlm_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PICK_BIT    = LINK_POS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rise,
   input  logic                fall,
   input  logic                start,
   input  logic [PHY_AW-1:0]   phy,
   input  logic [4:0]          regad,
   input  logic                mdio_i,
   output logic                mdio_o,
   output logic                mdio_oe,
   output logic                done,
   output logic                present,
   output logic                pick
);
   localparam int SH_W = PICK_BIT + 1;

   if (PICK_BIT < 0 || PICK_BIT > 15) begin : g_bad_pick
      $error("PICK_BIT must select one of the 16 data bits");
   end

   logic din;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign din = mdio_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '1;
         else        sr <= SYNC_STAGES'({sr, mdio_i});
      end
      assign din = sr[SYNC_STAGES-1];
   end

   fe_st_t          st;
   logic [5:0]      idx;
   logic [5:0]      nxt;
   logic [15:0]     hdr;
   logic [3:0]      hsel;
   logic            nbit;
   logic [SH_W-1:0] dsh;

   always_comb begin
      nxt  = idx + 6'd1;
      hsel = 4'(6'(HDR_END - 1) - nxt);
      if (nxt < 6'(PRE_BITS))     nbit = 1'b1;
      else if (nxt < 6'(HDR_END)) nbit = hdr[hsel];
      else                        nbit = 1'b1;
   end

   assign pick = dsh[SH_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= FE_IDLE;
         idx     <= '0;
         hdr     <= '0;
         dsh     <= '0;
         mdio_o  <= 1'b1;
         mdio_oe <= 1'b0;
         done    <= 1'b0;
         present <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            FE_IDLE: begin
               if (start) begin
                  hdr <= {2'b11, 2'b01, 2'b10, phy, regad};
                  st  <= FE_ARM;
               end
            end
            FE_ARM: begin
               if (fall) begin
                  idx     <= '0;
                  mdio_o  <= 1'b1;
                  mdio_oe <= 1'b1;
                  st      <= FE_RUN;
               end
            end
            FE_RUN: begin
               if (fall && idx != 6'(LAST_BIT)) begin
                  idx     <= nxt;
                  mdio_o  <= nbit;
                  mdio_oe <= (nxt < 6'(HDR_END));
               end
               if (rise) begin
                  if (idx == 6'(TA_LOW_BIT)) present <= ~din;
                  if (idx > 6'(TA_LOW_BIT))  dsh     <= SH_W'({dsh, din});
                  if (idx == 6'(LAST_BIT)) begin
                     done <= 1'b1;
                     st   <= FE_IDLE;
                  end
               end
            end
            default: st <= FE_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/mlm_poll_seq.sv
module mlm_poll_seq
   import mlm_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mon_en,
   input  logic [PHY_AW-1:0]  sel,
   input  logic               done,
   input  logic               present,
   input  logic               pick,
   input  logic [1:0]         evt_clr,
   output logic               start,
   output logic [PHY_AW-1:0]  phy,
   output logic [NUM_PHY-1:0] alive,
   output logic               scan_done,
   output logic               link,
   output logic [1:0]         evt
);
   seq_st_t           st;
   logic [PHY_AW-1:0] addr_q;
   logic [1:0]        evt_set;
   logic              new_link;

   always_comb begin
      start    = (st == SQ_SCAN_GO) || (st == SQ_MON_GO && mon_en);
      phy      = (st == SQ_SCAN_GO || st == SQ_SCAN_WAIT) ? addr_q : sel;
      new_link = present & pick;
      evt_set  = 2'b00;
      if (st == SQ_MON_WAIT && done && new_link != link)
         evt_set = new_link ? 2'b01 : 2'b10;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_SCAN_GO;
         addr_q    <= '0;
         alive     <= '0;
         scan_done <= 1'b0;
         link      <= 1'b0;
         evt       <= 2'b00;
      end else begin
         evt <= (evt & ~evt_clr) | evt_set;
         unique case (st)
            SQ_SCAN_GO:  st <= SQ_SCAN_WAIT;
            SQ_SCAN_WAIT: begin
               if (done) begin
                  alive[addr_q] <= present;
                  if (addr_q == '1) begin
                     scan_done <= 1'b1;
                     st        <= SQ_MON_GO;
                  end else begin
                     addr_q <= addr_q + 1'b1;
                     st     <= SQ_SCAN_GO;
                  end
               end
            end
            SQ_MON_GO: begin
               if (mon_en) st <= SQ_MON_WAIT;
            end
            SQ_MON_WAIT: begin
               if (done) begin
                  link <= new_link;
                  st   <= SQ_MON_GO;
               end
            end
            default: st <= SQ_SCAN_GO;
         endcase
      end
   end
endmodule

// File: rtl/mdio_link_monitor.sv
module mdio_link_monitor
   import mlm_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int DEF_HALF    = 4,
   parameter int SYNC_STAGES = 2,
   localparam int CTRL_W     = DIV_W + 8,
   localparam int RD_W       = NUM_PHY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [CTRL_W-1:0] reg_wdata,
   output logic [RD_W-1:0]   reg_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i,
   output logic              irq
);
   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div
      $error("DIV_W must lie in 2..16");
   end
   if (DEF_HALF < 1 || DEF_HALF >= (1 << DIV_W)) begin : g_bad_half
      $error("DEF_HALF must fit the divider field and be nonzero");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES >= DEF_HALF) begin : g_bad_sync
      $error("SYNC_STAGES must be below DEF_HALF so the sample settles");
   end

   logic [CTRL_W-1:0]  ctrl_q;
   logic [PHY_AW-1:0]  sel;
   logic               mon_en;
   logic [1:0]         irq_en;
   logic [DIV_W-1:0]   half;
   logic [1:0]         evt_clr;

   logic               rise_w, fall_w, start_w, done_w, present_w, pick_w;
   logic [PHY_AW-1:0]  phy_w;
   logic [NUM_PHY-1:0] alive_w;
   logic               scan_done_w, link_w;
   logic [1:0]         evt_w;

   assign sel    = ctrl_q[4:0];
   assign mon_en = ctrl_q[5];
   assign irq_en = ctrl_q[7:6];
   assign half   = ctrl_q[CTRL_W-1:8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ctrl_q <= {DIV_W'(DEF_HALF), 8'h00};
      else if (reg_wr && reg_addr == RA_CTRL) ctrl_q <= reg_wdata;
   end

   assign evt_clr = (reg_wr && reg_addr == RA_EVT) ? reg_wdata[1:0] : 2'b00;

   always_comb begin
      unique case (reg_addr)
         RA_CTRL:  reg_rdata = RD_W'(ctrl_q);
         RA_ALIVE: reg_rdata = alive_w;
         RA_STAT:  reg_rdata = RD_W'({scan_done_w, link_w});
         default:  reg_rdata = RD_W'(evt_w);
      endcase
   end

   assign irq = |(evt_w & irq_en);

   mlm_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
      .clk  (clk),
      .rst_n(rst_n),
      .half (half),
      .mdc  (mdc),
      .rise (rise_w),
      .fall (fall_w)
   );

   mlm_frame_engine #(.SYNC_STAGES(SYNC_STAGES), .PICK_BIT(LINK_POS)) u_fe (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise   (rise_w),
      .fall   (fall_w),
      .start  (start_w),
      .phy    (phy_w),
      .regad  (STATUS_REG),
      .mdio_i (mdio_i),
      .mdio_o (mdio_o),
      .mdio_oe(mdio_oe),
      .done   (done_w),
      .present(present_w),
      .pick   (pick_w)
   );

   mlm_poll_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mon_en   (mon_en),
      .sel      (sel),
      .done     (done_w),
      .present  (present_w),
      .pick     (pick_w),
      .evt_clr  (evt_clr),
      .start    (start_w),
      .phy      (phy_w),
      .alive    (alive_w),
      .scan_done(scan_done_w),
      .link     (link_w),
      .evt      (evt_w)
   );
endmodule

// File: rtl/mlm_checker.sv
module mlm_checker #(
   parameter int DIV_W = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe,
   input logic        irq,
   input logic        scan_done,
   input logic        link,
   input logic [1:0]  evt,
   input logic [31:0] alive
);
   logic           mdc_d;
   logic [DIV_W:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_d <= 1'b0;
         hold  <= '0;
      end else begin
         mdc_d <= mdc;
         if (mdc != mdc_d)           hold <= '0;
         else if (hold != {1'b1, {DIV_W{1'b0}}}) hold <= hold + 1'b1;
      end
   end

   // R2
   mdc_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold < (DIV_W+1)'(1 << DIV_W));

   // R3
   oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_oe) |-> $fell(mdc));

   // R3
   out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_o) |-> $fell(mdc));

   // R6
   alive_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_done && $past(scan_done)) |-> $stable(alive));

   // R8
   up_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt[0]) |-> $rose(link));

   // R8
   down_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt[1]) |-> $fell(link));

   // R10
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (evt != 2'b00));
endmodule

bind mdio_link_monitor mlm_checker #(.DIV_W(DIV_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mdc      (mdc),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe),
   .irq      (irq),
   .scan_done(scan_done_w),
   .link     (link_w),
   .evt      (evt_w),
   .alive    (alive_w)
);

// File: tb/tb_mdio_link_monitor.sv
`timescale 1ns/1ps
module tb_mdio_link_monitor;
   localparam int DIV_W = 8;
   localparam int DEF_HALF = 4;
   localparam logic [31:0] PRESENT = 32'h8001_0425;
   // step fields: {model link, clear mask[1:0], expected events[1:0]}
   localparam logic [4:0] STEPS [0:5] = '{
      5'b1_00_01, 5'b1_01_00, 5'b0_00_10, 5'b1_00_11, 5'b1_10_01, 5'b0_01_10};

   logic clk = 0, rst_n = 0;
   logic [1:0] reg_addr = 0;
   logic reg_wr = 0;
   logic [15:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic mdc, mdio_o, mdio_oe, mdio_i, irq;

   int total = 0, bad = 0;
   logic [31:0] phy_link = 0;
   logic phy_oe = 0, phy_bit = 1;
   logic [45:0] hsh = 0;
   int dcnt = 0, k = 0, nframes = 0, frame_err = 0;
   logic resp = 0;
   logic [4:0] cur = 0, last_addr = 0;
   logic [4:0] log_addr [0:31];
   logic [15:0] rsp_data;

   always #10 clk = ~clk;

   assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_bit : 1'b1);

   mdio_link_monitor #(.DIV_W(DIV_W), .DEF_HALF(DEF_HALF), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq));

   // PHY model: decodes headers on rising MDC, answers on falling MDC
   always @(posedge mdc or negedge mdc) begin
      if (mdc) begin
         if (mdio_oe) begin
            hsh = {hsh[44:0], mdio_o};
            dcnt = dcnt + 1;
         end else if (dcnt != 0) begin
            if (dcnt != 46 || hsh[45:14] != 32'hFFFF_FFFF || hsh[13:10] != 4'b0110 || hsh[4:0] != 5'd1)
               frame_err = frame_err + 1;
            cur = hsh[9:5];
            if (nframes < 32) log_addr[nframes] = cur;
            last_addr = cur;
            nframes = nframes + 1;
            resp = PRESENT[cur];
            rsp_data = 16'h7809 | (phy_link[cur] ? 16'h0004 : 16'h0000);
            k = 0;
            dcnt = 0;
         end
      end else if (resp) begin
         k = k + 1;
         if (k == 1) begin phy_oe <= 1'b1; phy_bit <= 1'b0; end
         else if (k <= 17) phy_bit <= rsp_data[17-k];
         else begin phy_oe <= 1'b0; resp = 0; end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [15:0] ctrl(input logic [4:0] s, input logic m, input logic [1:0] en, input logic [7:0] h);
      return {h, en, m, s};
   endfunction

   task automatic wait_frames(input int n);
      int target = nframes + n;
      while (nframes < target) @(posedge clk);
   endtask

   task automatic mdc_period(output int cyc);
      realtime t1, t2;
      @(posedge mdc); t1 = $realtime;
      @(posedge mdc); t2 = $realtime;
      cyc = int'((t2 - t1) / 20.0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      int p;
      repeat (3) @(posedge clk);
      check("R1 mdc in reset", {31'b0, mdc}, 0);
      @(negedge clk) rst_n = 1;
      #1;
      check("R1 mdc", {31'b0, mdc}, 0);
      check("R1 oe", {31'b0, mdio_oe}, 0);
      check("R1 irq", {31'b0, irq}, 0);
      reg_addr = 0; #1 check("R1 ctrl", reg_rdata, DEF_HALF << 8);
      reg_addr = 1; #1 check("R1 alive", reg_rdata, 0);
      reg_addr = 2; #1 check("R1 status", reg_rdata, 0);
      reg_addr = 3; #1 check("R1 events", reg_rdata, 0);

      // scan
      v = 0;
      while (v[1] == 1'b0) begin
         repeat (100) @(posedge clk);
         rd(2, v);
      end
      check("R6 scan done", {31'b0, v[1]}, 1);
      check("R4 scan frame count", nframes, 32);
      for (int i = 0; i < 32; i++) check("R4 scan order", {27'b0, log_addr[i]}, i);
      check("R3 frame format", frame_err, 0);
      rd(1, v);
      check("R5 alive bitmap", v, PRESENT);
      repeat (1500) @(posedge clk);
      check("R6 no frames without enable", nframes, 32);

      // monitor PHY 5 with both interrupt enables
      wr(0, ctrl(5'd5, 1'b1, 2'b11, 8'd4));
      wait_frames(2);
      rd(2, v); check("R8 initial link down", {31'b0, v[0]}, 0);
      rd(3, v); check("R8 no event initially", v, 0);
      for (int s = 0; s < 6; s++) begin
         wr(3, {14'b0, STEPS[s][3:2]});
         phy_link[5] = STEPS[s][4];
         wait_frames(2);
         rd(2, v); check("R8 link follows bit 2", {31'b0, v[0]}, {31'b0, STEPS[s][4]});
         rd(3, v); check("R9 events after W1C", v, {30'b0, STEPS[s][1:0]});
         check("R10 irq", {31'b0, irq}, {31'b0, |STEPS[s][1:0]});
      end
      check("R7 polled address", {27'b0, last_addr}, 5);

      // R10 enable masking, events now 2'b10
      wr(0, ctrl(5'd5, 1'b1, 2'b01, 8'd4));
      #1 check("R10 masked irq", {31'b0, irq}, 0);
      wr(0, ctrl(5'd5, 1'b1, 2'b10, 8'd4));
      #1 check("R10 enabled irq", {31'b0, irq}, 1);
      wr(3, 16'h0002);
      #1 check("R10 irq after clear", {31'b0, irq}, 0);

      // R11 bitmap is read-only
      wr(1, 16'h0000);
      rd(1, v); check("R11 bitmap unchanged", v, PRESENT);

      // R12 absent PHY reads link down
      phy_link[5] = 1'b1;
      wait_frames(2);
      wr(3, 16'h0003);
      rd(2, v); check("R12 link up before switch", {31'b0, v[0]}, 1);
      wr(0, ctrl(5'd3, 1'b1, 2'b11, 8'd4));
      wait_frames(2);
      rd(2, v); check("R12 absent PHY link", {31'b0, v[0]}, 0);
      rd(3, v); check("R12 down event", v, 2);
      check("R7 new selection polled", {27'b0, last_addr}, 3);

      // R2 divider
      mdc_period(p); check("R2 period half 4", p, 8);
      wr(0, ctrl(5'd3, 1'b0, 2'b00, 8'd3));
      repeat (20) @(posedge clk);
      mdc_period(p); check("R2 period half 3", p, 6);
      wr(0, ctrl(5'd3, 1'b0, 2'b00, 8'd0));
      repeat (20) @(posedge clk);
      mdc_period(p); check("R2 period half 0", p, 2);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule